// File: doc/BRIEF.md
# Split TLB Invalidate and Synchronize Controller

This block keeps the valid bits of two translation lookaside buffers, one for instruction fetches and one for data accesses. Each buffer is two-way set-associative with 64 sets. An invalidate request carries an effective address. The set index is taken from that address, and at the next clock edge both ways of that set are cleared in both buffers. No tag is compared, so four entries are dropped by one request. Each buffer has a refill port. A refill marks one way valid, and a one-bit least-recently-used flag per set picks that way. Each buffer also has a lookup port that reports per-way valid and a hit. Tag matching is not part of this block, so a hit only means that some way of the set is valid.

A synchronize request completes at once when the external system-wide synchronize input is low. If that input is high, the block raises a stall output and holds it until the input drops. Invalidates are still accepted while the stall is held. A one-cycle done pulse marks every completed invalidate and every completed synchronize. The reset is asynchronous and active-low, and the block releases it through a two-stage synchronizer.

Top module: `tlb_inval_sync_ctrl`

## Requirements
- R1: While reset is applied, and after it is released, every way of every set in both buffers reads invalid, and stall_o, inv_done_o and sync_done_o are 0.
- R2: The set index of an invalidate is inv_ea_i[17:12] in little-endian numbering, which is bits 14 to 19 in big-endian numbering of the 32-bit address. No other address bit changes which set is cleared.
- R3: At the clock edge that samples inv_req_i, both ways of the indexed set are cleared in both buffers. No tag is compared. All other sets keep their state.
- R4: A lookup of the set being invalidated in the same cycle reports both ways invalid and hit 0. A lookup of any other set in that cycle is unaffected.
- R5: inv_done_o is high for exactly the one cycle after each invalidate request. This holds while a synchronize stall is pending.
- R6: A refill sets the way named by the set's LRU flag valid and then inverts the flag. After reset every flag is 0, so successive refills of one set go way 0, way 1, way 0 and so on. An invalidate leaves the flags unchanged.
- R7: If a refill and an invalidate hit the same set in the same cycle, the invalidate wins. The set ends up empty and its LRU flag is unchanged.
- R8: A synchronize request sampled while ext_sync_i is low gives a sync_done_o pulse in the next cycle, and stall_o stays 0.
- R9: A synchronize request sampled while ext_sync_i is high raises stall_o from the next cycle. stall_o stays high with no done pulse for as long as ext_sync_i stays high. Further synchronize requests during the stall are ignored.
- R10: The first edge at which a held stall samples ext_sync_i low drops stall_o, and sync_done_o pulses in that same cycle.
- R11: A lookup hit output is the OR of that lookup's two way-valid outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_req_i | input | 1 | Invalidate request, one cycle per request |
| inv_ea_i | input | 32 | Effective address of the invalidate |
| sync_req_i | input | 1 | Synchronize request |
| ext_sync_i | input | 1 | System-wide invalidate-synchronize input, high means hold |
| ilk_idx_i | input | 6 | Instruction buffer lookup set |
| ilk_way_vld_o | output | 2 | Instruction buffer per-way valid of the looked-up set |
| ilk_hit_o | output | 1 | Instruction buffer lookup hit |
| dlk_idx_i | input | 6 | Data buffer lookup set |
| dlk_way_vld_o | output | 2 | Data buffer per-way valid of the looked-up set |
| dlk_hit_o | output | 1 | Data buffer lookup hit |
| ifill_en_i | input | 1 | Instruction buffer refill strobe |
| ifill_idx_i | input | 6 | Instruction buffer refill set |
| dfill_en_i | input | 1 | Data buffer refill strobe |
| dfill_idx_i | input | 6 | Data buffer refill set |
| inv_done_o | output | 1 | Invalidate completion pulse |
| sync_done_o | output | 1 | Synchronize completion pulse |
| stall_o | output | 1 | Execution stall after a synchronize |

## Verification
The lookup outputs are combinational on the registered state and on the invalidate in flight. The bench therefore checks the same-cycle miss 1 ns after driving, before the next rising edge. Invalidate and refill effects, inv_done_o, stall_o and sync_done_o each come from one register stage. The bench checks them at the falling edge that follows the sampling rising edge, and it checks again one cycle later to confirm that each pulse lasts one cycle. A bench model of the valid and LRU bits per set is updated at each rising edge from the stimulus alone. All 64 sets are swept through fill, invalidate and refill, and every result is compared against that model.

// File: rtl/tlbsc_pkg.sv
package tlbsc_pkg;
  localparam int ADDR_W   = 32;
  localparam int BE_FIRST = 14;
  localparam int BE_LAST  = 19;
  localparam int IDX_MSB  = ADDR_W - 1 - BE_FIRST;
  localparam int IDX_LSB  = ADDR_W - 1 - BE_LAST;
  localparam int IDX_W    = IDX_MSB - IDX_LSB + 1;
  localparam int SETS     = 1 << IDX_W;
  localparam int WAYS     = 2;
  localparam int NBUF     = 2;

  typedef enum logic {
    SYNC_IDLE = 1'b0,
    SYNC_HOLD = 1'b1
  } sync_state_e;
endpackage

// File: rtl/tlbsc_way_valid.sv
module tlbsc_way_valid
  import tlbsc_pkg::*;
#(
  parameter int N_SETS = SETS,
  parameter int I_W    = IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inv_en_i,
  input  logic [I_W-1:0]  inv_idx_i,
  input  logic            fill_en_i,
  input  logic [I_W-1:0]  fill_idx_i,
  input  logic [I_W-1:0]  lkp_idx_i,
  output logic [WAYS-1:0] lkp_vld_o
);
  logic [N_SETS-1:0][WAYS-1:0] vld_q, vld_d;
  logic [N_SETS-1:0]           lru_q, lru_d;
  logic                        fill_blocked;
  logic                        state_we;
  logic                        lkp_kill;

  assign fill_blocked = inv_en_i && (inv_idx_i == fill_idx_i);
  assign state_we     = inv_en_i | fill_en_i;

  always_comb begin
    vld_d = vld_q;
    lru_d = lru_q;
    if (fill_en_i && !fill_blocked) begin
      vld_d[fill_idx_i][lru_q[fill_idx_i]] = 1'b1;
      lru_d[fill_idx_i]                    = ~lru_q[fill_idx_i];
    end
    if (inv_en_i) begin
      vld_d[inv_idx_i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lru_q <= '0;
    end else if (state_we) begin
      vld_q <= vld_d;
      lru_q <= lru_d;
    end
  end

  assign lkp_kill  = inv_en_i && (inv_idx_i == lkp_idx_i);
  assign lkp_vld_o = lkp_kill ? '0 : vld_q[lkp_idx_i];

  // R3
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en_i |=> (vld_q[$past(inv_idx_i)] == '0));

  // R6
  fill_lru_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !fill_blocked) |=>
      ((lru_q[$past(fill_idx_i)] != $past(lru_q[fill_idx_i])) &&
       (vld_q[$past(fill_idx_i)] != '0)));

  // R7
  fill_lose_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_blocked && fill_en_i |=> $stable(lru_q));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_en_i && !fill_en_i) |=> $stable(vld_q));
endmodule

// File: rtl/tlbsc_sync_ctl.sv
module tlbsc_sync_ctl
  import tlbsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_req_i,
  input  logic ext_sync_i,
  output logic stall_o,
  output logic done_o
);
  sync_state_e state_q, state_d;
  logic        done_q, done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      SYNC_IDLE: begin
        if (sync_req_i) begin
          if (ext_sync_i) state_d = SYNC_HOLD;
          else            done_d  = 1'b1;
        end
      end
      SYNC_HOLD: begin
        if (!ext_sync_i) begin
          state_d = SYNC_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = SYNC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SYNC_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign stall_o = (state_q == SYNC_HOLD);
  assign done_o  = done_q;

  // R8
  sync_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req_i && !stall_o && !ext_sync_i) |=> (done_o && !stall_o));

  // R9
  sync_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req_i && !stall_o && ext_sync_i) |=> (stall_o && !done_o));

  // R9
  stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && ext_sync_i) |=> (stall_o && !done_o));

  // R10
  stall_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_o) |-> done_o);
endmodule

// File: rtl/tlb_inval_sync_ctrl.sv
module tlb_inval_sync_ctrl
  import tlbsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_req_i,
  input  logic [ADDR_W-1:0] inv_ea_i,
  input  logic              sync_req_i,
  input  logic              ext_sync_i,
  input  logic [IDX_W-1:0]  ilk_idx_i,
  output logic [WAYS-1:0]   ilk_way_vld_o,
  output logic              ilk_hit_o,
  input  logic [IDX_W-1:0]  dlk_idx_i,
  output logic [WAYS-1:0]   dlk_way_vld_o,
  output logic              dlk_hit_o,
  input  logic              ifill_en_i,
  input  logic [IDX_W-1:0]  ifill_idx_i,
  input  logic              dfill_en_i,
  input  logic [IDX_W-1:0]  dfill_idx_i,
  output logic              inv_done_o,
  output logic              sync_done_o,
  output logic              stall_o
);
  logic [1:0]                      rst_sync_q;
  logic                            rst_int_n;
  logic [IDX_W-1:0]                inv_idx;
  logic [ADDR_W-IDX_W-1:0]         ea_unused_bits;
  logic [NBUF-1:0]                 fill_en;
  logic [NBUF-1:0][IDX_W-1:0]      fill_idx;
  logic [NBUF-1:0][IDX_W-1:0]      lkp_idx;
  logic [NBUF-1:0][WAYS-1:0]       lkp_vld;
  logic                            inv_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign inv_idx        = inv_ea_i[IDX_MSB:IDX_LSB];
  assign ea_unused_bits = {inv_ea_i[ADDR_W-1:IDX_MSB+1], inv_ea_i[IDX_LSB-1:0]};

  assign fill_en  = {dfill_en_i, ifill_en_i};
  assign fill_idx = {dfill_idx_i, ifill_idx_i};
  assign lkp_idx  = {dlk_idx_i, ilk_idx_i};

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    tlbsc_way_valid #(
      .N_SETS (SETS),
      .I_W    (IDX_W)
    ) u_vld (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .inv_en_i   (inv_req_i),
      .inv_idx_i  (inv_idx),
      .fill_en_i  (fill_en[b]),
      .fill_idx_i (fill_idx[b]),
      .lkp_idx_i  (lkp_idx[b]),
      .lkp_vld_o  (lkp_vld[b])
    );
  end

  assign ilk_way_vld_o = lkp_vld[0];
  assign dlk_way_vld_o = lkp_vld[1];
  assign ilk_hit_o     = |lkp_vld[0];
  assign dlk_hit_o     = |lkp_vld[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) inv_done_q <= 1'b0;
    else            inv_done_q <= inv_req_i;
  end
  assign inv_done_o = inv_done_q;

  tlbsc_sync_ctl u_sync (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sync_req_i (sync_req_i),
    .ext_sync_i (ext_sync_i),
    .stall_o    (stall_o),
    .done_o     (sync_done_o)
  );

  // R5
  inv_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    inv_req_i |=> inv_done_o);

  // R5
  inv_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !inv_req_i |=> !inv_done_o);

  // R4
  same_set_miss_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inv_req_i && (inv_idx == ilk_idx_i)) |-> !ilk_hit_o);

  // R11
  hit_or_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dlk_hit_o == (dlk_way_vld_o != '0)) && (ilk_hit_o == (ilk_way_vld_o != '0)));
endmodule

// File: tb/tlb_inval_sync_ctrl_tb.sv
module tlb_inval_sync_ctrl_tb;
  localparam int NS = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inv_req_i, sync_req_i, ext_sync_i;
  logic [31:0] inv_ea_i;
  logic [5:0]  ilk_idx_i, dlk_idx_i, ifill_idx_i, dfill_idx_i;
  logic [1:0]  ilk_way_vld_o, dlk_way_vld_o;
  logic        ilk_hit_o, dlk_hit_o, ifill_en_i, dfill_en_i;
  logic        inv_done_o, sync_done_o, stall_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  logic [1:0] mv [2][NS];
  logic       ml [2][NS];

  always #10 clk = ~clk;

  tlb_inval_sync_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .inv_req_i(inv_req_i), .inv_ea_i(inv_ea_i),
    .sync_req_i(sync_req_i), .ext_sync_i(ext_sync_i),
    .ilk_idx_i(ilk_idx_i), .ilk_way_vld_o(ilk_way_vld_o), .ilk_hit_o(ilk_hit_o),
    .dlk_idx_i(dlk_idx_i), .dlk_way_vld_o(dlk_way_vld_o), .dlk_hit_o(dlk_hit_o),
    .ifill_en_i(ifill_en_i), .ifill_idx_i(ifill_idx_i),
    .dfill_en_i(dfill_en_i), .dfill_idx_i(dfill_idx_i),
    .inv_done_o(inv_done_o), .sync_done_o(sync_done_o), .stall_o(stall_o)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // one clock: model updates at the rising edge from the driven stimulus
  task automatic tick();
    logic [5:0] ii, fi;
    logic       fe;
    @(posedge clk);
    ii = inv_ea_i[17:12];
    for (int b = 0; b < 2; b++) begin
      fe = (b == 0) ? ifill_en_i : dfill_en_i;
      fi = (b == 0) ? ifill_idx_i : dfill_idx_i;
      if (fe && !(inv_req_i && ii == fi)) begin
        mv[b][fi][ml[b][fi]] = 1'b1;
        ml[b][fi] = ~ml[b][fi];
      end
      if (inv_req_i) mv[b][ii] = 2'b00;
    end
    @(negedge clk);
    inv_req_i = 0; ifill_en_i = 0; dfill_en_i = 0; sync_req_i = 0;
  endtask

  task automatic check_all(input string rq);
    for (int s = 0; s < NS; s++) begin
      ilk_idx_i = s[5:0];
      dlk_idx_i = s[5:0];
      #1;
      chk(rq, ilk_way_vld_o, mv[0][s]);
      chk(rq, dlk_way_vld_o, mv[1][s]);
      chk("R11", ilk_hit_o, |mv[0][s]);
      chk("R11", dlk_hit_o, |mv[1][s]);
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < NS; s++) begin mv[b][s] = 2'b00; ml[b][s] = 1'b0; end
    rst_n = 0; inv_req_i = 0; inv_ea_i = 0; sync_req_i = 0; ext_sync_i = 0;
    ilk_idx_i = 0; dlk_idx_i = 0; ifill_en_i = 0; dfill_en_i = 0;
    ifill_idx_i = 0; dfill_idx_i = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", stall_o, 0); chk("R1", inv_done_o, 0); chk("R1", sync_done_o, 0);
    chk("R1", ilk_way_vld_o, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", stall_o, 0);
    check_all("R1");

    // R6 fill sweep with varied per-set patterns
    for (int s = 0; s < NS; s++) begin
      ifill_en_i = 1; ifill_idx_i = s[5:0];
      dfill_en_i = 1; dfill_idx_i = s[5:0];
      tick();
      if (s % 2 == 1) begin ifill_en_i = 1; ifill_idx_i = s[5:0]; end
      if (s % 3 == 0) begin dfill_en_i = 1; dfill_idx_i = s[5:0]; end
      tick();
    end
    check_all("R6");

    // R2 R3 R4 R5 invalidate sweep with random upper and lower address bits
    for (int k = 0; k < NS; k++) begin
      inv_req_i = 1;
      inv_ea_i  = $urandom;
      inv_ea_i[17:12] = k[5:0];
      ilk_idx_i = k[5:0];
      dlk_idx_i = 6'((k + 1) % NS);
      #1;
      chk("R4", ilk_way_vld_o, 0);
      chk("R4", ilk_hit_o, 0);
      chk("R4", dlk_way_vld_o, mv[1][(k + 1) % NS]);
      tick();
      chk("R5", inv_done_o, 1);
      dlk_idx_i = k[5:0];
      #1;
      chk("R3", ilk_way_vld_o, 0);
      chk("R3", dlk_way_vld_o, 0);
      chk("R2", dlk_hit_o, 0);
    end
    @(negedge clk);
    chk("R5", inv_done_o, 0);
    check_all("R3");

    // R6 refill once per set: way follows the kept LRU flag
    for (int s = 0; s < NS; s++) begin
      ifill_en_i = 1; ifill_idx_i = s[5:0];
      dfill_en_i = 1; dfill_idx_i = s[5:0];
      tick();
    end
    check_all("R6");

    // R7 same-set fill and invalidate, other buffer fills a different set
    inv_req_i = 1; inv_ea_i = 32'h0000_9000;
    ifill_en_i = 1; ifill_idx_i = 6'd9;
    dfill_en_i = 1; dfill_idx_i = 6'd10;
    tick();
    ilk_idx_i = 6'd9; dlk_idx_i = 6'd10; #1;
    chk("R7", ilk_way_vld_o, 0);
    chk("R7", dlk_way_vld_o, mv[1][10]);
    ifill_en_i = 1; ifill_idx_i = 6'd9;
    tick();
    check_all("R7");

    // R2 all non-index address bits set, index 0
    inv_req_i = 1; inv_ea_i = ~(32'h3F << 12);
    tick();
    check_all("R2");

    // R8 sync pass-through
    ext_sync_i = 0; sync_req_i = 1;
    tick();
    chk("R8", sync_done_o, 1); chk("R8", stall_o, 0);
    tick();
    chk("R8", sync_done_o, 0); chk("R8", stall_o, 0);

    // R9 sync hold, repeated requests ignored, invalidate still taken
    ext_sync_i = 1; sync_req_i = 1;
    tick();
    chk("R9", stall_o, 1); chk("R9", sync_done_o, 0);
    for (int n = 0; n < 4; n++) begin
      sync_req_i = n[0];
      tick();
      chk("R9", stall_o, 1); chk("R9", sync_done_o, 0);
    end
    inv_req_i = 1; inv_ea_i = 32'h0001_4000;
    tick();
    chk("R5", inv_done_o, 1); chk("R9", stall_o, 1);
    ilk_idx_i = 6'd20; #1;
    chk("R5", ilk_way_vld_o, 0);

    // R10 release
    ext_sync_i = 0;
    tick();
    chk("R10", stall_o, 0); chk("R10", sync_done_o, 1);
    tick();
    chk("R10", sync_done_o, 0); chk("R10", stall_o, 0);
    check_all("R3");
    finish_run();
  end
endmodule